// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block sits behind an instruction fetch stream of 16-bit words and turns it into decoded instructions. The upper byte of the first word is the opcode. Its two most significant bits place the instruction in one of four groups. Three more opcode bits select one of six operand layouts: no operand, one register or flag, two registers, and each of these three followed by a second word that holds a 16-bit in-segment address. The decoder takes in one or two words as the layout requires. It then presents one registered bundle with a single-cycle valid strobe. The bundle holds the opcode, group, layout code, register fields and address.

Words arrive with a valid qualifier and may have any number of idle cycles between them, including between the two halves of a long instruction. Bits that a layout leaves unused must be zero. When they are not, the instruction is still decoded and consumed, and a bad-encoding flag marks it. Opcodes whose layout code is not defined are reported as illegal and consumed as single words. A synchronous reset drops any instruction that is half received.

Top module: `vld_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, and at the edge right after it, `dec_valid` is 0.
- R2: Each instruction produces exactly one `dec_valid` pulse, one cycle long. It appears at the rising edge after the edge that accepted the instruction's last word. No pulse appears at any other edge.
- R3: `dec_format` equals opcode bits 5..3 of the first word (word bits 13..11). The codes are 0 = no operand, 1 = one register, 2 = two registers, 3 = address only, 4 = one register plus address, 5 = two registers plus address.
- R4: `dec_opcode` is the first word's bits 15..8. `dec_group` is its bits 15..14, where 0 = ALU, 1 = memory, 2 = branch and 3 = other.
- R5: For codes 1, 2, 4 and 5, `dec_reg_a` is word bits 7..4. For codes 2 and 5, `dec_reg_b` is word bits 3..0. Any register output that a layout does not use reads 0.
- R6: For codes 3, 4 and 5, the decoder takes the next valid word as the address, however many idle cycles come first. That word appears on `dec_addr`. For codes 0, 1 and 2, `dec_addr` is 0.
- R7: `dec_bad_enc` is 1 for these cases: code 0 or 3 with any of word bits 7..0 set, or code 1 or 4 with any of word bits 3..0 set. The instruction is still decoded and emitted with its fields.
- R8: A layout code of 6 or 7 sets `dec_illegal_op`. Such an opcode is consumed as one word and reported with format 0, both register fields 0, address 0 and `dec_bad_enc` 0.
- R9: Asserting `rst` while waiting for an address word discards the pending first word. The next valid word is decoded as a new first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch word qualifier |
| in_word | input | 16 | Fetch word |
| dec_valid | output | 1 | One-cycle strobe: bundle below is a new instruction |
| dec_opcode | output | 8 | Opcode byte |
| dec_group | output | 2 | Opcode group |
| dec_format | output | 3 | Operand layout code |
| dec_reg_a | output | 4 | Destination or single register/flag index |
| dec_reg_b | output | 4 | Source register index |
| dec_addr | output | 16 | In-segment address of a two-word instruction |
| dec_illegal_op | output | 1 | Undefined layout code |
| dec_bad_enc | output | 1 | Non-zero reserved bits |

## Verification
Every result is due at the first rising edge after the edge that accepted the instruction's final word. That final word is the opcode word for short layouts and the address word for long ones. The bench drives words on falling edges and pushes one expected bundle when it drives an instruction's last word. The monitor samples 1 ns after each rising edge and pops one entry for every `dec_valid` it sees. A pulse with nothing queued, a missing pulse left over at the end, or one during idle gaps and around reset is therefore caught as a timing error, not only as a field error.

// File: rtl/vld_pkg.sv
package vld_pkg;

   localparam int FMT_W = 3;

   typedef enum logic [FMT_W-1:0] {
      LAY_BARE     = 3'd0,
      LAY_ONE      = 3'd1,
      LAY_PAIR     = 3'd2,
      LAY_ADR      = 3'd3,
      LAY_ONE_ADR  = 3'd4,
      LAY_PAIR_ADR = 3'd5
   } vld_lay_e;

   localparam int LAY_DEFINED = 6;

   function automatic logic lay_long(input vld_lay_e l);
      return (l == LAY_ADR) || (l == LAY_ONE_ADR) || (l == LAY_PAIR_ADR);
   endfunction

   function automatic logic lay_uses_a(input vld_lay_e l);
      return (l == LAY_ONE) || (l == LAY_PAIR) ||
             (l == LAY_ONE_ADR) || (l == LAY_PAIR_ADR);
   endfunction

   function automatic logic lay_uses_b(input vld_lay_e l);
      return (l == LAY_PAIR) || (l == LAY_PAIR_ADR);
   endfunction

endpackage

// File: rtl/vld_fmt_lut.sv
module vld_fmt_lut
   import vld_pkg::*;
#(
   parameter bit LUT_TABLE = 1'b1
) (
   input  logic [FMT_W-1:0] code,
   output vld_lay_e         lay,
   output logic             undef
);

   localparam int NCODE = 2 ** FMT_W;

   generate
      if (LUT_TABLE) begin : g_table
         vld_lay_e   tbl_lay   [NCODE];
         logic       tbl_undef [NCODE];
         for (genvar e = 0; e < NCODE; e++) begin : g_ent
            if (e < LAY_DEFINED) begin : g_def
               assign tbl_lay[e]   = vld_lay_e'(e);
               assign tbl_undef[e] = 1'b0;
            end else begin : g_res
               assign tbl_lay[e]   = LAY_BARE;
               assign tbl_undef[e] = 1'b1;
            end
         end
         assign lay   = tbl_lay[code];
         assign undef = tbl_undef[code];
      end else begin : g_case
         always_comb begin
            undef = 1'b0;
            case (code)
               3'd0:    lay = LAY_BARE;
               3'd1:    lay = LAY_ONE;
               3'd2:    lay = LAY_PAIR;
               3'd3:    lay = LAY_ADR;
               3'd4:    lay = LAY_ONE_ADR;
               3'd5:    lay = LAY_PAIR_ADR;
               default: begin
                  lay   = LAY_BARE;
                  undef = 1'b1;
               end
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/vld_field_extract.sv
module vld_field_extract
   import vld_pkg::*;
#(
   parameter int LOW_W = 8,
   parameter int REG_W = 4
) (
   input  logic [LOW_W-1:0] operand,
   input  vld_lay_e         lay,
   input  logic             undef,
   output logic [REG_W-1:0] reg_a,
   output logic [REG_W-1:0] reg_b,
   output logic             bad_enc
);

   localparam int NSLOT = LOW_W / REG_W;
   localparam int TOP   = NSLOT - 1;

   generate
      if (NSLOT != 2) begin : g_bad_slots
         $error("vld_field_extract: operand must hold exactly two register slots");
      end
   endgenerate

   logic [NSLOT-1:0] slot_nz;
   logic [NSLOT-1:0] slot_rsv;
   logic             no_regs;
   logic             one_reg;

   assign no_regs = !lay_uses_a(lay);
   assign one_reg = lay_uses_a(lay) && !lay_uses_b(lay);

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         assign slot_nz[s] = |operand[s*REG_W +: REG_W];
         if (s == TOP) begin : g_top
            assign slot_rsv[s] = no_regs;
         end else begin : g_low
            assign slot_rsv[s] = no_regs || one_reg;
         end
      end
   endgenerate

   assign reg_a   = (!undef && lay_uses_a(lay)) ? operand[TOP*REG_W +: REG_W] : '0;
   assign reg_b   = (!undef && lay_uses_b(lay)) ? operand[0 +: REG_W] : '0;
   assign bad_enc = !undef && (|(slot_nz & slot_rsv));

endmodule

// File: rtl/vld_word_seq.sv
module vld_word_seq #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   input  logic              head_long,
   output logic [WORD_W-1:0] head_word,
   output logic              pend,
   output logic              emit,
   output logic [WORD_W-1:0] emit_addr
);

   logic [WORD_W-1:0] hold_q;
   logic              pend_q;

   assign pend      = pend_q;
   assign head_word = pend_q ? hold_q : in_word;
   assign emit      = in_valid && (pend_q || !head_long);
   assign emit_addr = pend_q ? in_word : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         hold_q <= '0;
      end else if (in_valid) begin
         if (pend_q) begin
            pend_q <= 1'b0;
         end else if (head_long) begin
            pend_q <= 1'b1;
            hold_q <= in_word;
         end
      end
   end

endmodule

// File: rtl/vld_decoder.sv
module vld_decoder
   import vld_pkg::*;
#(
   parameter int WORD_W    = 16,
   parameter int OPC_W     = 8,
   parameter int REG_W     = 4,
   parameter int GRP_W     = 2,
   parameter int FMT_LSB   = 3,
   parameter bit LUT_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_word,
   output logic              dec_valid,
   output logic [OPC_W-1:0]  dec_opcode,
   output logic [GRP_W-1:0]  dec_group,
   output logic [2:0]        dec_format,
   output logic [REG_W-1:0]  dec_reg_a,
   output logic [REG_W-1:0]  dec_reg_b,
   output logic [WORD_W-1:0] dec_addr,
   output logic              dec_illegal_op,
   output logic              dec_bad_enc
);

   localparam int LOW_W = WORD_W - OPC_W;

   generate
      if (OPC_W + 2 * REG_W != WORD_W) begin : g_chk_split
         $error("vld_decoder: opcode plus two register fields must fill a word");
      end
      if (FMT_LSB + FMT_W > OPC_W - GRP_W) begin : g_chk_fmt
         $error("vld_decoder: layout field overlaps the group bits");
      end
      if (FMT_W != 3) begin : g_chk_fw
         $error("vld_decoder: layout code port is three bits wide");
      end
   endgenerate

   logic [WORD_W-1:0] head_word;
   logic              seq_pend;
   logic              emit;
   logic [WORD_W-1:0] emit_addr;
   vld_lay_e          head_lay;
   logic              head_undef;
   logic [REG_W-1:0]  ex_reg_a;
   logic [REG_W-1:0]  ex_reg_b;
   logic              ex_bad;
   logic [OPC_W-1:0]  head_opc;

   assign head_opc = head_word[WORD_W-1 -: OPC_W];

   vld_word_seq #(
      .WORD_W (WORD_W)
   ) seq_i (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_word   (in_word),
      .head_long (lay_long(head_lay)),
      .head_word (head_word),
      .pend      (seq_pend),
      .emit      (emit),
      .emit_addr (emit_addr)
   );

   vld_fmt_lut #(
      .LUT_TABLE (LUT_TABLE)
   ) lut_i (
      .code  (head_opc[FMT_LSB +: FMT_W]),
      .lay   (head_lay),
      .undef (head_undef)
   );

   vld_field_extract #(
      .LOW_W (LOW_W),
      .REG_W (REG_W)
   ) fex_i (
      .operand (head_word[LOW_W-1:0]),
      .lay     (head_lay),
      .undef   (head_undef),
      .reg_a   (ex_reg_a),
      .reg_b   (ex_reg_b),
      .bad_enc (ex_bad)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         dec_valid      <= 1'b0;
         dec_opcode     <= '0;
         dec_group      <= '0;
         dec_format     <= '0;
         dec_reg_a      <= '0;
         dec_reg_b      <= '0;
         dec_addr       <= '0;
         dec_illegal_op <= 1'b0;
         dec_bad_enc    <= 1'b0;
      end else begin
         dec_valid <= emit;
         if (emit) begin
            dec_opcode     <= head_opc;
            dec_group      <= head_opc[OPC_W-1 -: GRP_W];
            dec_format     <= head_lay;
            dec_reg_a      <= ex_reg_a;
            dec_reg_b      <= ex_reg_b;
            dec_addr       <= emit_addr;
            dec_illegal_op <= head_undef;
            dec_bad_enc    <= ex_bad;
         end
      end
   end

endmodule

// File: rtl/vld_decoder_chk.sv
module vld_decoder_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              seq_pend,
   input logic              dec_valid,
   input logic [2:0]        dec_format,
   input logic              dec_illegal_op,
   input logic              dec_bad_enc,
   input logic [WORD_W-1:0] dec_addr
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |=> !dec_valid);

   // R9
   reset_drops_chk: assert property (@(posedge clk) rst |=> !seq_pend);

   // R2
   strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
      dec_valid |-> $past(in_valid));

   // R6
   addr_arrival_chk: assert property (@(posedge clk) disable iff (rst)
      (seq_pend && in_valid) |=> dec_valid);

   // R6
   long_waited_chk: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && dec_format >= 3'd3) |-> $past(seq_pend));

   // R6
   short_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && dec_format < 3'd3) |-> dec_addr == '0);

   // R8
   illegal_shape_chk: assert property (@(posedge clk) disable iff (rst)
      (dec_valid && dec_illegal_op) |-> (dec_format == 3'd0 && !dec_bad_enc));

endmodule

bind vld_decoder vld_decoder_chk #(.WORD_W(WORD_W)) chk_i (
   .clk            (clk),
   .rst            (rst),
   .in_valid       (in_valid),
   .seq_pend       (seq_pend),
   .dec_valid      (dec_valid),
   .dec_format     (dec_format),
   .dec_illegal_op (dec_illegal_op),
   .dec_bad_enc    (dec_bad_enc),
   .dec_addr       (dec_addr)
);

// File: tb/vld_decoder_tb_top.sv
module vld_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_word = '0;
   logic        dec_valid;
   logic [7:0]  dec_opcode;
   logic [1:0]  dec_group;
   logic [2:0]  dec_format;
   logic [3:0]  dec_reg_a;
   logic [3:0]  dec_reg_b;
   logic [15:0] dec_addr;
   logic        dec_illegal_op;
   logic        dec_bad_enc;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   vld_decoder dut_i (
      .clk            (clk),
      .rst            (rst),
      .in_valid       (in_valid),
      .in_word        (in_word),
      .dec_valid      (dec_valid),
      .dec_opcode     (dec_opcode),
      .dec_group      (dec_group),
      .dec_format     (dec_format),
      .dec_reg_a      (dec_reg_a),
      .dec_reg_b      (dec_reg_b),
      .dec_addr       (dec_addr),
      .dec_illegal_op (dec_illegal_op),
      .dec_bad_enc    (dec_bad_enc)
   );

   typedef struct {
      logic [7:0]  opc;
      logic [1:0]  grp;
      logic [2:0]  fmt;
      logic [3:0]  ra;
      logic [3:0]  rb;
      logic [15:0] adr;
      logic        ill;
      logic        bad;
   } exp_t;

   exp_t exp_q[$];

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Model built from the requirement text only.
   function automatic exp_t model(input logic [15:0] w, input logic [15:0] a);
      exp_t e;
      logic [2:0] code;
      code  = w[13:11];
      e.opc = w[15:8];
      e.grp = w[15:14];
      e.ill = (code >= 3'd6);
      e.fmt = e.ill ? 3'd0 : code;
      e.ra  = (!e.ill && (code == 1 || code == 2 || code == 4 || code == 5)) ? w[7:4] : 4'd0;
      e.rb  = (!e.ill && (code == 2 || code == 5)) ? w[3:0] : 4'd0;
      e.adr = (!e.ill && code >= 3) ? a : 16'd0;
      e.bad = 1'b0;
      if (!e.ill && (code == 0 || code == 3)) e.bad = |w[7:0];
      if (!e.ill && (code == 1 || code == 4)) e.bad = |w[3:0];
      return e;
   endfunction

   task automatic drive(input logic [15:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 16'hxxxx;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Single-word instruction: expected result pushed as the word is driven.
   task automatic send_one(input logic [15:0] w);
      @(negedge clk);
      exp_q.push_back(model(w, 16'd0));
      in_valid = 1'b1;
      in_word  = w;
   endtask

   // Two-word instruction with a gap before the address word (R6).
   task automatic send_two(input logic [15:0] w, input logic [15:0] a, input int gap);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      for (int i = 0; i < gap; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_word  = 16'hxxxx;
      end
      @(negedge clk);
      exp_q.push_back(model(w, a));
      in_valid = 1'b1;
      in_word  = a;
   endtask

   task automatic stop_drive();
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 16'hxxxx;
   endtask

   // Monitor: pops one expected bundle per strobe (R2 timing).
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (!rst && dec_valid) begin
            if (exp_q.size() == 0) begin
               check("R2", "unexpected strobe", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check("R4", "opcode", 32'(dec_opcode), 32'(e.opc));
               check("R4", "group", 32'(dec_group), 32'(e.grp));
               check("R3", "format", 32'(dec_format), 32'(e.fmt));
               check("R5", "reg_a", 32'(dec_reg_a), 32'(e.ra));
               check("R5", "reg_b", 32'(dec_reg_b), 32'(e.rb));
               check("R6", "addr", 32'(dec_addr), 32'(e.adr));
               check("R8", "illegal", 32'(dec_illegal_op), 32'(e.ill));
               check("R7", "bad_enc", 32'(dec_bad_enc), 32'(e.bad));
            end
         end
      end
   end

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=expired expected=finished");
         finish_run();
      end
   end

   initial begin
      // R1: quiet through reset and on the edge after it
      repeat (3) @(posedge clk);
      #1 check("R1", "valid in reset", 32'(dec_valid), 32'd0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1 check("R1", "valid after reset", 32'(dec_valid), 32'd0);

      // R3 R4 R5 single words of each group, back to back
      send_one(16'h0100);   // group 0, code 0
      send_one(16'h4A50);   // group 1, code 1, reg 5
      send_one(16'h90A3);   // group 2, code 2, regs A/3
      stop_drive();
      idle(2);

      // R6 two-word layouts, with and without gaps
      send_two(16'hDF00, 16'h1234, 0);   // code 3
      send_two(16'h2070, 16'hBEEF, 1);   // code 4
      send_two(16'h69C4, 16'hFFFF, 3);   // code 5
      send_one(16'h90A3);                // right after an address word
      stop_drive();
      idle(2);

      // R7 non-zero reserved bits: decoded and consumed
      send_one(16'h0105);
      send_one(16'h4A51);
      send_two(16'hDF80, 16'h0001, 0);
      send_two(16'h2071, 16'h00AA, 2);
      send_one(16'h90FF);               // two-reg layout has no reserved bits
      stop_drive();
      idle(2);

      // R8 undefined layout codes, one word each, even with operand bits
      send_one(16'hB0FF);
      send_one(16'hFFFF);
      send_one(16'h3A00);
      send_one(16'h0100);
      stop_drive();
      idle(2);

      // R9 reset between the two halves drops the first word
      drive(16'hDF00);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1 check("R9", "valid after mid reset", 32'(dec_valid), 32'd0);
      send_one(16'h4A30);
      stop_drive();
      idle(3);

      check("R2", "outstanding results", 32'(exp_q.size()), 32'd0);
      done = 1'b1;
      finish_run();
   end

endmodule